// File: doc/BRIEF.md
# Packet-Aware Round-Robin Crossbar Scheduler

This block picks which input of an N-port input-queued crossbar may send to which output in each time slot. Every input holds one queue per output. Each queue's state is reported as an occupancy bit, together with a flag that is set when the head cell ends a packet. The block runs request, grant and accept rounds with round-robin pointers. It repeats them up to log2(N) times within the slot, so that ports still left unmatched can pair up. The result is a registered match matrix in which every input and every output appears at most once.

Each output is set independently to cell mode or packet mode. A cell-mode output follows the classic pointer rules. A packet-mode output connects to an input and stays locked to it until that input has moved the cell that closes the packet. While locked, the output ignores requests from every other input, even in slots where the locked input has no cell ready. Cells of one packet can therefore be forwarded before the whole packet has arrived, and cells from different packets are never interleaved at that output. An input that holds such a lock accepts the locked output's grant before any other grant.

Matrix bit `i*N + j` always refers to input `i` and output `j`. This holds for the request, end-of-packet and match vectors.

Top module: `pktislip_sched`

## Requirements
- R1: After reset `match_vld` is 0, `match` is all zero, no output is locked, and every pointer is 0. With N=4 and all sixteen queues occupied in cell mode, the first slot therefore returns exactly the pairs (0,0) and (1,1).
- R2: `match` never holds more than one 1 in any input row or any output column.
- R3: A match bit is set only where the matching request bit was set in the slot that produced it.
- R4: The grant pointer of a cell-mode output moves to one past the input that accepted it, and only when that accept happened in the first round. With N=4, the second all-occupied slot after reset returns (0,1), (1,0) and (2,2).
- R5: The accept pointer of an input moves to one past the output it accepted, and only on a first-round accept.
- R6: A packet-mode output that has transferred a cell without the end flag is locked to that input. It grants no other input, even when the locked input is not requesting.
- R7: The lock is released when a cell flagged end-of-packet is transferred through the locked pair. The output then competes normally again. Setting the output to cell mode also drops its lock at the next slot.
- R8: An input that receives a grant from an output locked to it accepts that grant, even when its accept pointer favours another granting output.
- R9: Later rounds match only ports left free by earlier rounds. A slot runs ceil(log2 N) rounds, with at least one.
- R10: When `slot_en` is 0, `match_vld` and `match` are 0 on the next cycle, and no pointer or lock changes.
- R11: The grant pointer of a packet-mode output moves only when a first-round accept at that output carries the end-of-packet flag.
- R12: The result of a slot presented with `slot_en` high appears on `match` with `match_vld` high one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | 1 | Run a scheduling slot this cycle |
| voq_req | input | N*N | Queue occupied, bit i*N+j = input i toward output j |
| voq_eop | input | N*N | Head cell of that queue closes its packet |
| out_pkt_mode | input | N | 1 = output j runs in packet mode, 0 = cell mode |
| match | output | N*N | Registered match matrix, bit i*N+j |
| match_vld | output | 1 | `match` holds the result of the previous enabled slot |

## Verification
Some properties can be checked on every cycle without knowing the scheduling history. These are the permutation shape of `match`, the rule that a match needs a request, the fact that an idle slot freezes the state, the way a locked output restricts its grants, and the preference an input gives to its locked output. Assertions cover them. The pointer arithmetic, the exact pairs chosen, the lock lifetime across a cut-through gap and the release on end-of-packet all depend on state built up over many slots. Only the bench's directed packet scenarios and its long sweep against an independently written slot model can show those.

// File: rtl/pislip_pkg.sv
package pislip_pkg;

  localparam int unsigned MAXP = 16;
  typedef logic [MAXP-1:0] vec_t;

  // circular first-set search starting at ptr over n positions
  function automatic vec_t rr_pick(vec_t req, int unsigned ptr, int unsigned n);
    vec_t r;
    logic found;
    r = '0;
    found = 1'b0;
    for (int unsigned k = 0; k < MAXP; k++) begin
      int unsigned idx;
      idx = (ptr + k) % n;
      if (k < n && !found && req[idx[3:0]]) begin
        r[idx[3:0]] = 1'b1;
        found = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic int unsigned oh2idx(vec_t v);
    int unsigned r;
    r = 0;
    for (int unsigned k = 0; k < MAXP; k++)
      if (v[k]) r = k;
    return r;
  endfunction

  function automatic int unsigned wrap_next(int unsigned idx, int unsigned n);
    return (idx + 1) % n;
  endfunction

endpackage

// File: rtl/islip_grant.sv
module islip_grant #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_col,
  input  logic          out_free,
  input  logic [PW-1:0] ptr,
  input  logic          lock_on,
  input  logic [PW-1:0] lock_src,
  output logic [N-1:0]  gnt
);
  import pislip_pkg::*;

  logic [N-1:0] src_mask;
  logic [N-1:0] eligible;
  vec_t         pick;

  always_comb begin
    src_mask = '0;
    src_mask[lock_src] = 1'b1;
    eligible = lock_on ? (req_col & src_mask) : req_col;
    pick     = rr_pick(vec_t'(eligible), int'(ptr), N);
    gnt      = out_free ? pick[N-1:0] : '0;
  end

  assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_locked_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_on |-> ((gnt & ~src_mask) == '0));

endmodule

// File: rtl/islip_accept.sv
module islip_accept #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  gnt_row,
  input  logic          in_free,
  input  logic [PW-1:0] ptr,
  input  logic [N-1:0]  lock_row,
  output logic [N-1:0]  acc
);
  import pislip_pkg::*;

  logic [N-1:0] pref;
  logic [N-1:0] cand;
  vec_t         pick;

  always_comb begin
    pref = gnt_row & lock_row;
    cand = (pref != '0) ? pref : gnt_row;
    pick = rr_pick(vec_t'(cand), int'(ptr), N);
    acc  = in_free ? pick[N-1:0] : '0;
  end

  assert_one_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc));

  assert_lock_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_free && ((gnt_row & lock_row) != '0)) |-> ((acc & lock_row) != '0));

  assert_accept_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc & ~gnt_row) == '0));

endmodule

// File: rtl/islip_iter.sv
module islip_iter #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N*N-1:0]        req,
  input  logic [N-1:0]          in_free,
  input  logic [N-1:0]          out_free,
  input  logic [N-1:0][PW-1:0]  gptr,
  input  logic [N-1:0][PW-1:0]  aptr,
  input  logic [N-1:0]          lock_eff,
  input  logic [N-1:0][PW-1:0]  lock_src,
  output logic [N*N-1:0]        acc
);

  logic [N-1:0][N-1:0] req_col;   // [output][input]
  logic [N-1:0][N-1:0] gnt_col;   // [output][input]
  logic [N-1:0][N-1:0] gnt_row;   // [input][output]
  logic [N-1:0][N-1:0] lock_row;  // [input][output]
  logic [N-1:0][N-1:0] acc_row;   // [input][output]

  always_comb begin
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        req_col[j][i]  = req[i*N+j] & in_free[i];
        gnt_row[i][j]  = gnt_col[j][i];
        lock_row[i][j] = lock_eff[j] && (lock_src[j] == PW'(i));
        acc[i*N+j]     = acc_row[i][j];
      end
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_out
    islip_grant #(.N(N), .PW(PW)) u_grant (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_col  (req_col[j]),
      .out_free (out_free[j]),
      .ptr      (gptr[j]),
      .lock_on  (lock_eff[j]),
      .lock_src (lock_src[j]),
      .gnt      (gnt_col[j])
    );
  end

  for (genvar i = 0; i < N; i++) begin : g_in
    islip_accept #(.N(N), .PW(PW)) u_accept (
      .clk      (clk),
      .rst_n    (rst_n),
      .gnt_row  (gnt_row[i]),
      .in_free  (in_free[i]),
      .ptr      (aptr[i]),
      .lock_row (lock_row[i]),
      .acc      (acc_row[i])
    );
  end

endmodule

// File: rtl/pktislip_sched.sv
module pktislip_sched #(
  parameter int N    = 4,
  parameter int PW   = (N > 1) ? $clog2(N) : 1,
  parameter int ITER = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           slot_en,
  input  logic [N*N-1:0] voq_req,
  input  logic [N*N-1:0] voq_eop,
  input  logic [N-1:0]   out_pkt_mode,
  output logic [N*N-1:0] match,
  output logic           match_vld
);
  import pislip_pkg::*;

  localparam int NN = N * N;

  // scheduler state
  logic [N-1:0][PW-1:0] gptr_q, aptr_q, lsrc_q;
  logic [N-1:0]         lock_q;
  logic [NN-1:0]        match_q;
  logic                 vld_q;

  logic [N-1:0]         lock_eff;
  logic [ITER:0][NN-1:0]   cum;
  logic [ITER-1:0][NN-1:0] it_acc;
  logic [NN-1:0]        match_c;

  // named internal events
  logic [N-1:0]         first_hit_out, first_hit_in;
  logic [N-1:0][PW-1:0] first_src_out, first_dst_in;
  logic [N-1:0]         xfer_out, xfer_eop;
  logic [N-1:0][PW-1:0] xfer_src;
  logic [N-1:0]         gptr_move;

  assign lock_eff = lock_q & out_pkt_mode;
  assign cum[0]   = '0;

  for (genvar k = 0; k < ITER; k++) begin : g_round
    logic [N-1:0] in_free_k, out_free_k;
    always_comb begin
      for (int i = 0; i < N; i++) begin
        in_free_k[i]  = ~|cum[k][i*N +: N];
        out_free_k[i] = 1'b1;
      end
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (cum[k][i*N+j]) out_free_k[j] = 1'b0;
    end

    islip_iter #(.N(N), .PW(PW)) u_iter (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (voq_req),
      .in_free  (in_free_k),
      .out_free (out_free_k),
      .gptr     (gptr_q),
      .aptr     (aptr_q),
      .lock_eff (lock_eff),
      .lock_src (lsrc_q),
      .acc      (it_acc[k])
    );

    assign cum[k+1] = cum[k] | it_acc[k];

    assert_round_disjoint_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((it_acc[k] & cum[k]) == '0));
  end

  assign match_c = cum[ITER];

  always_comb begin
    for (int j = 0; j < N; j++) begin
      logic [N-1:0] col_first, col_all, col_eop;
      for (int i = 0; i < N; i++) begin
        col_first[i] = it_acc[0][i*N+j];
        col_all[i]   = match_c[i*N+j];
        col_eop[i]   = match_c[i*N+j] & voq_eop[i*N+j];
      end
      first_hit_out[j] = |col_first;
      first_src_out[j] = PW'(oh2idx(vec_t'(col_first)));
      xfer_out[j]      = |col_all;
      xfer_src[j]      = PW'(oh2idx(vec_t'(col_all)));
      xfer_eop[j]      = |col_eop;
      gptr_move[j]     = first_hit_out[j] && (!out_pkt_mode[j] || xfer_eop[j]);
    end
    for (int i = 0; i < N; i++) begin
      first_hit_in[i] = |it_acc[0][i*N +: N];
      first_dst_in[i] = PW'(oh2idx(vec_t'(it_acc[0][i*N +: N])));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gptr_q  <= '0;
      aptr_q  <= '0;
      lsrc_q  <= '0;
      lock_q  <= '0;
      match_q <= '0;
      vld_q   <= 1'b0;
    end else if (slot_en) begin
      match_q <= match_c;
      vld_q   <= 1'b1;
      for (int j = 0; j < N; j++) begin
        if (gptr_move[j])
          gptr_q[j] <= PW'(wrap_next(int'(first_src_out[j]), N));
        if (!out_pkt_mode[j]) begin
          lock_q[j] <= 1'b0;
        end else if (xfer_out[j]) begin
          lock_q[j] <= !xfer_eop[j];
          lsrc_q[j] <= xfer_src[j];
        end
      end
      for (int i = 0; i < N; i++)
        if (first_hit_in[i])
          aptr_q[i] <= PW'(wrap_next(int'(first_dst_in[i]), N));
    end else begin
      match_q <= '0;
      vld_q   <= 1'b0;
    end
  end

  assign match     = match_q;
  assign match_vld = vld_q;

  // ---------------- assertions ----------------
  for (genvar a = 0; a < N; a++) begin : g_chk
    logic [N-1:0] row_v, col_v;
    always_comb
      for (int b = 0; b < N; b++) begin
        row_v[b] = match_q[a*N+b];
        col_v[b] = match_q[b*N+a];
      end

    assert_row_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(row_v));
    assert_col_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col_v));

    assert_unlock_on_eop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_en && out_pkt_mode[a] && xfer_eop[a]) |=> !lock_q[a]);

    assert_pkt_ptr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_en && out_pkt_mode[a] && !xfer_eop[a]) |=> $stable(gptr_q[a]));
  end

  assert_match_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en) |=> ((match & ~$past(voq_req)) == '0));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_en |=> (!match_vld && match == '0 && $stable(gptr_q) && $stable(aptr_q)
                  && $stable(lock_q)));

  assert_result_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    slot_en |=> match_vld);

endmodule

// File: tb/pktislip_sched_tb.sv
module pktislip_sched_tb;

  localparam int N  = 4;
  localparam int NN = N * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slot_en = 1'b0;
  logic [NN-1:0] voq_req = '0;
  logic [NN-1:0] voq_eop = '0;
  logic [N-1:0]  out_pkt_mode = '0;
  logic [NN-1:0] match;
  logic          match_vld;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // reference model state
  int gp[N], ap[N], lk[N], ls[N];
  logic [NN-1:0] exp_m;
  logic [31:0]   seed = 32'h1234_5678;

  always #2 clk = ~clk;

  pktislip_sched #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .voq_req(voq_req),
    .voq_eop(voq_eop), .out_pkt_mode(out_pkt_mode),
    .match(match), .match_vld(match_vld)
  );

  function automatic logic [31:0] rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  task automatic check(input bit ok, input string req, input logic [NN-1:0] act,
                       input logic [NN-1:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < N; k++) begin gp[k] = 0; ap[k] = 0; lk[k] = 0; ls[k] = 0; end
  endtask

  // compute expected match for the current inputs, update model when en
  task automatic model_slot(input bit en);
    bit in_used[N], out_used[N];
    int gto[N];
    int first_src[N], first_dst[N];
    logic [NN-1:0] m;
    m = '0;
    for (int k = 0; k < N; k++) begin
      in_used[k] = 0; out_used[k] = 0; first_src[k] = -1; first_dst[k] = -1;
    end
    for (int r = 0; r < 2; r++) begin
      for (int j = 0; j < N; j++) begin
        gto[j] = -1;
        if (!out_used[j])
          for (int s = 0; s < N; s++) begin
            int i;
            i = (gp[j] + s) % N;
            if (gto[j] < 0 && !in_used[i] && voq_req[i*N+j] &&
                (!(lk[j] != 0 && out_pkt_mode[j]) || ls[j] == i))
              gto[j] = i;
          end
      end
      for (int i = 0; i < N; i++) begin
        int pick;
        pick = -1;
        if (!in_used[i]) begin
          for (int s = 0; s < N; s++) begin
            int j;
            j = (ap[i] + s) % N;
            if (pick < 0 && gto[j] == i && lk[j] != 0 && out_pkt_mode[j] && ls[j] == i)
              pick = j;
          end
          for (int s = 0; s < N; s++) begin
            int j;
            j = (ap[i] + s) % N;
            if (pick < 0 && gto[j] == i) pick = j;
          end
        end
        if (pick >= 0) begin
          m[i*N+pick] = 1'b1;
          in_used[i] = 1; out_used[pick] = 1;
          if (r == 0) begin first_src[pick] = i; first_dst[i] = pick; end
        end
      end
    end
    exp_m = m;
    if (en) begin
      for (int j = 0; j < N; j++) begin
        if (first_src[j] >= 0 && (!out_pkt_mode[j] || voq_eop[first_src[j]*N+j]))
          gp[j] = (first_src[j] + 1) % N;
        if (!out_pkt_mode[j]) lk[j] = 0;
        else
          for (int i = 0; i < N; i++)
            if (m[i*N+j]) begin lk[j] = voq_eop[i*N+j] ? 0 : 1; ls[j] = i; end
      end
      for (int i = 0; i < N; i++)
        if (first_dst[i] >= 0) ap[i] = (first_dst[i] + 1) % N;
    end
  endtask

  // one slot: drive at negedge, sample at the following negedge
  task automatic run_slot(input bit en, input logic [NN-1:0] rq, input logic [NN-1:0] eo,
                          input logic [N-1:0] md, input string tag);
    @(negedge clk);
    slot_en = en; voq_req = rq; voq_eop = eo; out_pkt_mode = md;
    model_slot(en);
    @(negedge clk);
    check(match_vld == en, {tag, " valid"}, NN'(match_vld), NN'(en));
    check(match == (en ? exp_m : '0), tag, match, en ? exp_m : '0);
    slot_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; slot_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  function automatic bit is_partial_perm(logic [NN-1:0] m);
    for (int a = 0; a < N; a++) begin
      int rc, cc;
      rc = 0; cc = 0;
      for (int b = 0; b < N; b++) begin rc += int'(m[a*N+b]); cc += int'(m[b*N+a]); end
      if (rc > 1 || cc > 1) return 0;
    end
    return 1;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    do_reset();
    @(negedge clk);
    check(match_vld == 1'b0 && match == '0, "R1 reset state", match, '0);

    // R1: all queues occupied, cell mode: pairs (0,0),(1,1)
    run_slot(1, '1, '0, '0, "R1 first slot model");
    check(match == 16'h0021, "R1 first slot pairs", match, 16'h0021);
    // R4/R5: pointers moved only by first-round accept
    run_slot(1, '1, '0, '0, "R4 second slot model");
    check(match == 16'h0412, "R4 R5 second slot pairs", match, 16'h0412);

    // R10: idle slot leaves outputs low and state untouched
    run_slot(0, '1, '0, '0, "R10 idle slot");
    run_slot(1, '1, '0, '0, "R10 state kept after idle");

    // packet scenario, output 0 in packet mode
    do_reset();
    run_slot(1, 16'h0110, 16'h0000, 4'b0001, "R6 lock set");
    check(match == 16'h0010, "R6 first packet cell to input 1", match, 16'h0010);
    run_slot(1, 16'h0100, 16'h0000, 4'b0001, "R6 cut-through gap");
    check(match == 16'h0000, "R6 other input ignored while locked", match, 16'h0000);
    run_slot(1, 16'h0130, 16'h0000, 4'b0001, "R8 locked accept");
    check(match == 16'h0010, "R8 input 1 keeps locked output", match, 16'h0010);
    run_slot(1, 16'h0110, 16'h0010, 4'b0001, "R7 eop transfer");
    check(match == 16'h0010, "R7 eop cell sent", match, 16'h0010);
    run_slot(1, 16'h0110, 16'h0000, 4'b0001, "R7 unlocked");
    check(match == 16'h0100, "R7 R11 output moves to input 2", match, 16'h0100);
    // R7: mode change to cell drops the lock from input 2
    run_slot(1, 16'h0110, 16'h0000, 4'b0000, "R7 mode drop");
    run_slot(1, 16'h0110, 16'h0000, 4'b0000, "R7 cell after drop");

    // sweep against model
    do_reset();
    begin
      logic [N-1:0] md;
      md = '0;
      for (int t = 0; t < 3000; t++) begin
        logic [31:0] r1, r2, r3;
        r1 = rnd(); r2 = rnd(); r3 = rnd();
        if (t % 64 == 0) md = r3[N-1:0];
        run_slot(r3[7:5] != 3'd0, NN'(r1 | r2), NN'(r1 & r2 & r3), md, "R9 R11 R12 sweep");
        check(is_partial_perm(match), "R2 partial permutation", match, '0);
        check((match & ~voq_req) == '0, "R3 match within requests", match, voq_req);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule